// File: doc/BRIEF.md
# Segmented Ones-Complement Accumulator

This block is a W-bit accumulating register used as the arithmetic stage of a built-in self-test pattern source. On every enabled clock it adds an addend bus, normally driven by a test counter, into its stored value. The addition uses ones-complement arithmetic: any carry out of the top of a sum is added back in at the bottom.

A one-hot select sets a segment length k. The register then splits into independent k-bit slices starting at bit 0. The slice at the top keeps whatever bits remain, so it may be shorter than k. Each slice adds on its own and folds its own carry back into itself. No carry passes between slices, so one W-bit register acts as several narrow accumulators working side by side. The whole addition, including the fold-back, resolves within one cycle.

Top module: `seg_oc_acc`

## Requirements
- R1: An active-low asynchronous reset forces acc_o to zero at once, and acc_o stays zero while the reset is held.
- R2: When clr_i is high at a rising edge, acc_o becomes zero after that edge, whatever en_i is. clr_i has priority over en_i.
- R3: When en_i and clr_i are both low at an edge, acc_o keeps its value, whatever the addend and select are.
- R4: When en_i is high and clr_i is low, each slice takes (slice of acc + slice of addend) in ones-complement form. A carry out of the slice's top bit is added into the slice's bit 0. The result shows on acc_o after that single edge. Example for k=3: 111+001 gives 001, and 110+100 gives 011.
- R5: If select bit j (bit 0 = least significant) is the lowest bit set, then k = j+1. Slices cover bits [k-1:0], [2k-1:k], and so on. The top slice takes the remaining bits.
- R6: A carry never crosses from one slice into the next.
- R7: With k=1, each bit is its own slice, so 1+1 gives 1 and each bit becomes the OR of the old bit and the addend bit.
- R8: If the select is all zero, the register is a single W-bit slice. If more than one select bit is set, the lowest set bit decides k.
- R9: Adding an all-zero addend leaves acc_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Accumulate enable |
| clr_i | input | 1 | Synchronous clear to zero |
| seg_sel_i | input | W | One-hot slice length select, bit j means k=j+1 |
| addend_i | input | W | Value added on each enabled edge |
| acc_o | output | W | Accumulator value |

## Verification
acc_o comes straight from the register, so a wrong slice boundary or a wrong fold-back carry shows on the port in the very next cycle.

A carry that leaks between slices makes a higher slice gain 1 that it should not have. The stimulus therefore drives sums that overflow a slice and checks that the slice above stays unchanged. A wrongly decoded select shifts the slice boundaries, so the bench sweeps several k values, an all-zero select and a select with two bits set.

// File: rtl/seg_acc_pkg.sv
package seg_acc_pkg;
  // per-bit slice position flags
  typedef struct packed {
    logic first;  // lowest bit of its slice
    logic last;   // highest bit of its slice
  } bit_role_t;
endpackage

// File: rtl/seg_acc_decode.sv
module seg_acc_decode
  import seg_acc_pkg::*;
#(
  parameter int unsigned W = 7,
  localparam int unsigned KW = $clog2(W + 1)
) (
  input  logic [W-1:0] sel_i,
  output bit_role_t    role_o [W]
);
  logic [KW-1:0] k_len;
  logic [KW-1:0] k_m1;

  // lowest set bit wins; none set selects one full-width slice
  always_comb begin
    k_len = KW'(W);
    for (int j = W - 1; j >= 0; j--) begin
      if (sel_i[j]) k_len = KW'(j + 1);
    end
  end

  assign k_m1 = k_len - 1'b1;

  always_comb begin
    logic [KW-1:0] pos;
    pos = '0;
    for (int i = 0; i < W; i++) begin
      role_o[i].first = (pos == '0);
      role_o[i].last  = (pos == k_m1) || (i == W - 1);
      pos = (pos == k_m1) ? '0 : pos + 1'b1;
    end
  end
endmodule

// File: rtl/seg_acc_add.sv
module seg_acc_add
  import seg_acc_pkg::*;
#(
  parameter int unsigned W = 7
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  bit_role_t    role_i [W],
  output logic [W-1:0] sum_o
);
  logic [W-1:0] raw_sum;
  logic [W-1:0] raw_co;
  logic [W-1:0] wrap_c;
  logic [W-1:0] p;
  logic [W-1:0] g;

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_pg
      assign p[gi] = a_i[gi] ^ b_i[gi];
      assign g[gi] = a_i[gi] & b_i[gi];
    end
  endgenerate

  // pass 1: ripple, carry killed at each slice start
  always_comb begin
    logic c;
    c = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (role_i[i].first) c = 1'b0;
      raw_sum[i] = p[i] ^ c;
      raw_co[i]  = g[i] | (p[i] & c);
      c = raw_co[i];
    end
  end

  // pass 2: broadcast each slice's top carry down to its bits
  always_comb begin
    logic e;
    e = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (role_i[i].last) e = raw_co[i];
      wrap_c[i] = e;
    end
  end

  // pass 3: end-around increment; cannot overflow the slice again
  always_comb begin
    logic c;
    c = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (role_i[i].first) c = wrap_c[i];
      sum_o[i] = raw_sum[i] ^ c;
      c = raw_sum[i] & c;
    end
  end
endmodule

// File: rtl/seg_oc_acc.sv
module seg_oc_acc
  import seg_acc_pkg::*;
#(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         clr_i,
  input  logic [W-1:0] seg_sel_i,
  input  logic [W-1:0] addend_i,
  output logic [W-1:0] acc_o
);
  bit_role_t    role [W];
  logic [W-1:0] acc_q;
  logic [W-1:0] acc_d;

  seg_acc_decode #(.W(W)) u_decode (
    .sel_i  (seg_sel_i),
    .role_o (role)
  );

  seg_acc_add #(.W(W)) u_add (
    .a_i    (acc_q),
    .b_i    (addend_i),
    .role_i (role),
    .sum_o  (acc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (en_i)   acc_q <= acc_d;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/seg_oc_acc_chk.sv
module seg_oc_acc_chk #(
  parameter int unsigned W = 7
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         en_i,
  input logic         clr_i,
  input logic [W-1:0] seg_sel_i,
  input logic [W-1:0] addend_i,
  input logic [W-1:0] acc_o
);
  a_r2_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> acc_o == '0);

  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !en_i) |=> $stable(acc_o));

  a_r7_k1_or: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && seg_sel_i[0]) |=> acc_o == ($past(acc_o) | $past(addend_i)));

  a_r9_zero_add: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && addend_i == '0) |=> $stable(acc_o));
endmodule

bind seg_oc_acc seg_oc_acc_chk #(.W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .clr_i     (clr_i),
  .seg_sel_i (seg_sel_i),
  .addend_i  (addend_i),
  .acc_o     (acc_o)
);

// File: tb/tb_seg_oc_acc.sv
`timescale 1ns/1ps
module tb_seg_oc_acc;
  localparam int unsigned W = 7;
  localparam int unsigned NV = 13;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         en_i = 1'b0;
  logic         clr_i = 1'b0;
  logic [W-1:0] seg_sel_i = '0;
  logic [W-1:0] addend_i = '0;
  logic [W-1:0] acc_o;

  int n_cmp = 0;
  int n_mis = 0;

  always #10 clk_i = ~clk_i;

  seg_oc_acc #(.W(W)) dut (
    .clk_i, .rst_ni, .en_i, .clr_i, .seg_sel_i, .addend_i, .acc_o
  );

  // {select, addend, expected acc after the edge}, en=1 clr=0, from acc=0
  localparam logic [3*W-1:0] VEC [NV] = '{
    {7'h04, 7'h07, 7'h07},  // R4 k=3: 000+111
    {7'h04, 7'h01, 7'h01},  // R4 111+001 wraps to 001
    {7'h04, 7'h02, 7'h03},  // R4
    {7'h04, 7'h03, 7'h06},  // R4
    {7'h04, 7'h04, 7'h03},  // R4 110+100 wraps to 011
    {7'h04, 7'h78, 7'h7B},  // R5 upper slices 3-bit and 1-bit
    {7'h04, 7'h48, 7'h4B},  // R6 mid slice wraps, bit 6 untouched
    {7'h40, 7'h40, 7'h0C},  // R5 k=7 single slice wrap
    {7'h00, 7'h7F, 7'h0C},  // R8 zero select = full width
    {7'h01, 7'h31, 7'h3D},  // R7 k=1 OR
    {7'h06, 7'h17, 7'h15},  // R8 two bits set, k=2 wins
    {7'h08, 7'h7C, 7'h12},  // R5 k=4 with 3-bit top slice
    {7'h20, 7'h7F, 7'h52}   // R5 k=6 with 1-bit top slice
  };

  task automatic chk(input string req, input logic [W-1:0] exp);
    n_cmp++;
    if (acc_o !== exp) begin
      n_mis++;
      $display("FAIL %s: acc_o=%h expected %h", req, acc_o, exp);
    end
  endtask

  task automatic step(input logic en, input logic clr,
                      input logic [W-1:0] sel, input logic [W-1:0] add);
    en_i = en; clr_i = clr; seg_sel_i = sel; addend_i = add;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_cmp++; n_mis++;
    $display("FAIL watchdog: acc_o=%h expected run end", acc_o);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 held in reset", '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after release", '0);

    for (int i = 0; i < NV; i++) begin
      step(1'b1, 1'b0, VEC[i][3*W-1:2*W], VEC[i][2*W-1:W]);
      chk($sformatf("R4/R5/R6/R7/R8 vector %0d", i), VEC[i][W-1:0]);
    end

    step(1'b0, 1'b0, 7'h04, 7'h7F);
    chk("R3 hold with enable low", 7'h52);
    step(1'b1, 1'b0, 7'h04, 7'h00);
    chk("R9 zero addend", 7'h52);
    step(1'b1, 1'b1, 7'h04, 7'h7F);
    chk("R2 clear beats enable", '0);
    step(1'b1, 1'b0, 7'h01, 7'h7F);
    chk("R7 k=1 fill", 7'h7F);
    step(1'b1, 1'b0, 7'h01, 7'h7F);
    chk("R7 k=1 one plus one", 7'h7F);
    step(1'b1, 1'b0, 7'h04, 7'h01);
    chk("R6 low wrap only", 7'h79);

    #5 rst_ni = 1'b0;
    #1 chk("R1 asynchronous", '0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    step(1'b1, 1'b0, 7'h00, 7'h05);
    chk("R8 full width add", 7'h05);
    step(1'b0, 1'b1, 7'h00, 7'h7F);
    chk("R2 clear with enable low", '0);

    finish_run();
  end
endmodule